// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Pair

This block holds two reloadable down-counters of `CNT_W` bits each (16 by default). Each counter has a base register that holds the period minus one, and a mode byte. The mode byte starts or stops the counter, forces a load from the base, and picks the count source. The count source is the I/O clock itself, the clock divided by `DIV_A` (8), or the clock divided by `DIV_B` (32). The upper counter has one more source: it steps once for each underflow of the lower counter. The two counters then act as one 32-bit down-counter.

Software programs the block through a simple register port. The port writes the two bases, the combined mode word and the two interrupt control registers. It can read back every register and the combined count. On underflow, each counter can latch an interrupt request. The request reaches the output only while the enable bit is set.

Register addresses are: 0 lower base, 1 upper base, 2 mode word (lower mode in bits 7:0, upper mode in bits 15:8), 3 lower interrupt control, 4 upper interrupt control, 5 combined count (upper counter in bits 31:16, lower in 15:0). Other addresses read as zero. A mode byte has run in bit 7, init in bit 6 and source in bits 1:0. The source codes are 0 direct, 1 divide-by-`DIV_A`, 2 divide-by-`DIV_B`, and 3 chained on the upper counter (no source at all on the lower one). Mode bits 5:2 read back as zero. Interrupt control has enable in bit 0, detect in bit 1 and request in bit 2.

Top module: `casc_timer_pair`

## Requirements
- R1: After reset, all bases, modes, counts and interrupt control bits read as zero and both interrupt outputs are low.
- R2: A running counter with init clear decrements by one on each tick of its source. Source 0 ticks every cycle. Source 1 ticks on every 8th cycle and source 2 on every 32nd cycle of a shared prescaler that starts at reset. On the lower counter, source 3 never ticks.
- R3: A tick that finds the count at 0 reloads the base and signals an underflow, so one period spans base+1 ticks.
- R4: While init (mode bit 6) is set, the counter loads its base on every cycle, whatever the run bit says, and produces no underflow or request.
- R5: With run (mode bit 7) and init clear, the counter holds its value; writing a mode byte of zero stops a counter.
- R6: With source 3, the upper counter steps on the same clock edge as each lower underflow and on no other edge, so the pair counts as one 32-bit counter.
- R7: The upper counter with sources 0 to 2 counts from the same ticks as the lower counter.
- R8: One write to address 2 updates both mode bytes at once; a mode change takes effect from the edge after the write.
- R9: An underflow while detect is set latches request; each interrupt output equals enable AND request of its counter.
- R10: Writing 1 to request clears it, but an underflow that sets request on the same edge wins.
- R11: With detect clear, an underflow leaves request unchanged.
- R12: The combined count read returns both counters from the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | CNT_W | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 2*CNT_W | Read data, combinational from reg_raddr |
| irq_out | output | 2 | Interrupt outputs, bit 0 lower counter, bit 1 upper counter |

## Verification
Directed runs try each tick source, with small bases, so that the 8- and 32-cycle prescaler phases can be told apart from a direct count and from each other. Chained runs with small bases on both halves separate a true cascade from an upper counter that ticks on its own. Cases with base 0 make an underflow happen on every tick, so that a request clear can collide with a new underflow. A long random phase with small random bases, modes and control writes, checked every cycle against a bench model, mixes init, stop and source changes at arbitrary moments.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_DIV_A  = 2'd1,
        SRC_DIV_B  = 2'd2,
        SRC_CHAIN  = 2'd3
    } src_e;

    typedef struct packed {
        logic       run;
        logic       init;
        logic [3:0] spare;
        src_e       src;
    } mode_t;

    typedef struct packed {
        logic req;
        logic det;
        logic en;
    } ictl_t;

    typedef enum logic [2:0] {
        A_BASE_LO = 3'd0,
        A_BASE_HI = 3'd1,
        A_MODE    = 3'd2,
        A_ICTL_LO = 3'd3,
        A_ICTL_HI = 3'd4,
        A_COUNT   = 3'd5
    } addr_e;

    localparam int MODE_W = 8;

    function automatic mode_t byte_to_mode(input logic [MODE_W-1:0] b);
        mode_t m;
        m.run   = b[7];
        m.init  = b[6];
        m.spare = '0;
        m.src   = src_e'(b[1:0]);
        return m;
    endfunction

endpackage

// File: rtl/ct_prescale.sv
module ct_prescale #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_a,
    output logic tick_b
);
    localparam int PW = $clog2(DIV_B);
    localparam int AW = $clog2(DIV_A);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d       = pre_q;
        pre_d.phase = PW'(pre_q.phase + 1'b1);
        tick_a      = &pre_q.phase[AW-1:0];
        tick_b      = &pre_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/ct_down_unit.sv
module ct_down_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         init,
    input  logic [W-1:0] base,
    output logic [W-1:0] cnt,
    output logic         uf
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } unit_t;

    unit_t u_d, u_q;

    always_comb begin
        u_d = u_q;
        uf  = 1'b0;
        if (init) begin
            u_d.cnt = base;
        end else if (run && tick) begin
            if (u_q.cnt == '0) begin
                u_d.cnt = base;
                uf      = 1'b1;
            end else begin
                u_d.cnt = u_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign cnt = u_q.cnt;
endmodule

// File: rtl/ct_irq_ctrl.sv
module ct_irq_ctrl
    import casc_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uf,
    input  logic       wr,
    input  logic [2:0] wbits,
    output ictl_t      ctl,
    output logic       irq
);
    ictl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr) begin
            c_d.en  = wbits[0];
            c_d.det = wbits[1];
            if (wbits[2]) c_d.req = 1'b0;
        end
        if (uf && c_q.det) c_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ctl = c_q;
    assign irq = c_q.en & c_q.req;
endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
    import casc_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_A = 8,
    parameter int DIV_B = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    input  logic [2:0]         reg_raddr,
    output logic [2*CNT_W-1:0] reg_rdata,
    output logic [1:0]         irq_out
);
    localparam int          PAIR_W    = 2 * CNT_W;
    localparam int          N_UNIT    = 2;
    localparam logic [2:0]  ICTL_BASE = A_ICTL_LO;

    typedef struct packed {
        logic [N_UNIT-1:0][CNT_W-1:0] base;
        mode_t [N_UNIT-1:0]           mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic                         tick_a, tick_b;
    logic [N_UNIT-1:0]            tick;
    logic [N_UNIT-1:0]            uf;
    logic [N_UNIT-1:0][CNT_W-1:0] cnt;
    logic [N_UNIT-1:0][CNT_W-1:0] base_q;
    ictl_t [N_UNIT-1:0]           ictl;
    logic [N_UNIT-1:0]            run_v, init_v, req_v, det_v;
    logic                         chain1;

    ct_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_a (tick_a),
        .tick_b (tick_b)
    );

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_addr)
                A_BASE_LO: cfg_d.base[0] = reg_wdata;
                A_BASE_HI: cfg_d.base[1] = reg_wdata;
                A_MODE: begin
                    for (int j = 0; j < N_UNIT; j++)
                        cfg_d.mode[j] = byte_to_mode(reg_wdata[j*MODE_W +: MODE_W]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // tick routing: the upper unit may follow lower underflows
    always_comb begin
        for (int j = 0; j < N_UNIT; j++) begin
            case (cfg_q.mode[j].src)
                SRC_DIRECT: tick[j] = 1'b1;
                SRC_DIV_A:  tick[j] = tick_a;
                SRC_DIV_B:  tick[j] = tick_b;
                default:    tick[j] = (j > 0) ? uf[0] : 1'b0;
            endcase
        end
    end

    for (genvar i = 0; i < N_UNIT; i++) begin : g_unit
        ct_down_unit #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick[i]),
            .run   (cfg_q.mode[i].run),
            .init  (cfg_q.mode[i].init),
            .base  (cfg_q.base[i]),
            .cnt   (cnt[i]),
            .uf    (uf[i])
        );

        ct_irq_ctrl u_irq (
            .clk   (clk),
            .rst_n (rst_n),
            .uf    (uf[i]),
            .wr    (reg_wr && (reg_addr == ICTL_BASE + 3'(i))),
            .wbits (reg_wdata[2:0]),
            .ctl   (ictl[i]),
            .irq   (irq_out[i])
        );

        assign run_v[i]  = cfg_q.mode[i].run;
        assign init_v[i] = cfg_q.mode[i].init;
        assign req_v[i]  = ictl[i].req;
        assign det_v[i]  = ictl[i].det;
        assign base_q[i] = cfg_q.base[i];
    end

    assign chain1 = (cfg_q.mode[1].src == SRC_CHAIN);

    // read mux: both halves of the count come from the same registers
    always_comb begin
        case (reg_raddr)
            A_BASE_LO: reg_rdata = PAIR_W'(base_q[0]);
            A_BASE_HI: reg_rdata = PAIR_W'(base_q[1]);
            A_MODE:    reg_rdata = PAIR_W'({cfg_q.mode[1], cfg_q.mode[0]});
            A_ICTL_LO: reg_rdata = PAIR_W'({req_v[0], det_v[0], ictl[0].en});
            A_ICTL_HI: reg_rdata = PAIR_W'({req_v[1], det_v[1], ictl[1].en});
            A_COUNT:   reg_rdata = {cnt[1], cnt[0]};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/casc_timer_pair_chk.sv
module casc_timer_pair_chk #(
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             tick,
    input logic [1:0]             run,
    input logic [1:0]             init,
    input logic                   chain1,
    input logic [1:0][CNT_W-1:0]  base,
    input logic [1:0][CNT_W-1:0]  cnt,
    input logic [1:0]             uf,
    input logic [1:0]             req,
    input logic [1:0]             det
);
    a_r4_init_loads_base: assert property (@(posedge clk) disable iff (!rst_n)
        init[0] |=> cnt[0] == $past(base[0]));

    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !init[0]) |=> $stable(cnt[0]));

    a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && !init[0] && tick[0] && cnt[0] == '0) |=> cnt[0] == $past(base[0]));

    a_r6_chain_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (chain1 && run[1] && !init[1] && !uf[0]) |=> $stable(cnt[1]));

    a_r9_req_from_uf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req[0]) |-> $past(uf[0] && det[0]));

    a_r10_uf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (uf[1] && det[1]) |=> req[1]);

    a_r11_no_det_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!det[1] && !req[1]) |=> !req[1]);
endmodule

bind casc_timer_pair casc_timer_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run_v),
    .init   (init_v),
    .chain1 (chain1),
    .base   (base_q),
    .cnt    (cnt),
    .uf     (uf),
    .req    (req_v),
    .det    (det_v)
);

// File: tb/casc_timer_pair_bench.sv
`timescale 1ns/1ps
module casc_timer_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = 3'd5;
    logic [31:0] reg_rdata;
    logic [1:0]  irq_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    casc_timer_pair u_casc_timer_pair (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // bench model
    int         m_pc;
    logic [15:0] m_base [2];
    logic [7:0]  m_mode [2];
    logic [15:0] m_cnt  [2];
    logic        m_en [2], m_det [2], m_req [2];

    function automatic logic pick(logic [1:0] s, logic ta, logic tb, logic ch);
        case (s)
            2'd0: return 1'b1;
            2'd1: return ta;
            2'd2: return tb;
            default: return ch;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_base[0]};
            3'd1: return {16'h0, m_base[1]};
            3'd2: return {16'h0, m_mode[1], m_mode[0]};
            3'd3: return {29'h0, m_req[0], m_det[0], m_en[0]};
            3'd4: return {29'h0, m_req[1], m_det[1], m_en[1]};
            3'd5: return {m_cnt[1], m_cnt[0]};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0;
            for (int i = 0; i < 2; i++) begin
                m_base[i] = '0; m_mode[i] = '0; m_cnt[i] = '0;
                m_en[i] = 0; m_det[i] = 0; m_req[i] = 0;
            end
        end else begin
            logic ta, tb, t, u0, u1;
            logic set [2];
            ta = (m_pc % 8) == 7;
            tb = (m_pc % 32) == 31;
            m_pc = (m_pc + 1) % 32;
            u0 = 0; u1 = 0;
            t = pick(m_mode[0][1:0], ta, tb, 1'b0);
            if (m_mode[0][6]) m_cnt[0] = m_base[0];
            else if (m_mode[0][7] && t) begin
                if (m_cnt[0] == 0) begin m_cnt[0] = m_base[0]; u0 = 1; end
                else m_cnt[0] = m_cnt[0] - 1;
            end
            t = pick(m_mode[1][1:0], ta, tb, u0);
            if (m_mode[1][6]) m_cnt[1] = m_base[1];
            else if (m_mode[1][7] && t) begin
                if (m_cnt[1] == 0) begin m_cnt[1] = m_base[1]; u1 = 1; end
                else m_cnt[1] = m_cnt[1] - 1;
            end
            set[0] = u0 && m_det[0];
            set[1] = u1 && m_det[1];
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_base[0] = reg_wdata;
                    3'd1: m_base[1] = reg_wdata;
                    3'd2: begin
                        m_mode[0] = {reg_wdata[7:6], 4'h0, reg_wdata[1:0]};
                        m_mode[1] = {reg_wdata[15:14], 4'h0, reg_wdata[9:8]};
                    end
                    3'd3, 3'd4: begin
                        int k;
                        k = (reg_addr == 3'd3) ? 0 : 1;
                        m_en[k] = reg_wdata[0];
                        m_det[k] = reg_wdata[1];
                        if (reg_wdata[2]) m_req[k] = 0;
                    end
                    default: ;
                endcase
            end
            for (int i = 0; i < 2; i++) if (set[i]) m_req[i] = 1;
        end
    end

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    // called right after a falling edge: compare count and irq
    task automatic look(string rq, string rq_irq);
        reg_raddr = 3'd5;
        #0.2;
        chk(rq, reg_rdata, model_read(3'd5));
        chk(rq_irq, {30'h0, irq_out}, {30'h0, m_en[1] & m_req[1], m_en[0] & m_req[0]});
    endtask

    task automatic look_all(string rq);
        for (int a = 0; a < 8; a++) begin
            reg_raddr = 3'(a);
            #0.1;
            chk(rq, reg_rdata, model_read(3'(a)));
        end
        reg_raddr = 3'd5;
    endtask

    // one cycle: check at the falling edge, then drive
    task automatic cyc(logic wr, logic [2:0] a, logic [15:0] d, string rq, string rq_irq);
        @(negedge clk);
        look(rq, rq_irq);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle(int n, string rq, string rq_irq);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'h0, rq, rq_irq);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(posedge clk);
        @(negedge clk);
        look_all("R1");
        chk("R1", {30'h0, irq_out}, 32'h0);
        rst_n = 1'b1;

        // R4: init held with run clear loads base, no request
        cyc(1, 3'd3, 16'h0003, "R1", "R1");
        cyc(1, 3'd0, 16'h0005, "R4", "R4");
        cyc(1, 3'd2, 16'h0040, "R4", "R4");
        idle(6, "R4", "R4");
        @(negedge clk); look_all("R4");

        // R2, R3, R9: direct count with reload and request
        cyc(1, 3'd2, 16'h0080, "R8", "R9");
        idle(20, "R3", "R9");

        // R10: base 0 underflows every tick, clear collides
        cyc(1, 3'd0, 16'h0000, "R3", "R9");
        idle(3, "R3", "R9");
        cyc(1, 3'd3, 16'h0007, "R10", "R10");
        idle(2, "R10", "R10");
        @(negedge clk); look_all("R10");

        // R5: mode zero stops both counters
        cyc(1, 3'd0, 16'h0009, "R5", "R5");
        cyc(1, 3'd2, 16'h0000, "R5", "R5");
        cyc(1, 3'd3, 16'h0004, "R5", "R5");
        idle(10, "R5", "R5");

        // R11: detect clear keeps request low
        cyc(1, 3'd3, 16'h0001, "R11", "R11");
        cyc(1, 3'd2, 16'h0080, "R11", "R11");
        idle(30, "R11", "R11");
        @(negedge clk); look_all("R11");

        // R6, R8, R12: chained pair, both modes in one write
        cyc(1, 3'd0, 16'h0003, "R6", "R9");
        cyc(1, 3'd1, 16'h0002, "R6", "R9");
        cyc(1, 3'd4, 16'h0003, "R6", "R9");
        cyc(1, 3'd2, 16'hC3C0, "R8", "R9");
        cyc(1, 3'd2, 16'h8380, "R8", "R9");
        @(negedge clk); look_all("R8");
        idle(40, "R12", "R9");

        // R2, R7: divided sources on both counters
        cyc(1, 3'd0, 16'h0002, "R2", "R9");
        cyc(1, 3'd1, 16'h0001, "R2", "R9");
        cyc(1, 3'd2, 16'h8281, "R7", "R9");
        idle(200, "R2", "R9");
        cyc(1, 3'd2, 16'h8183, "R7", "R9");
        idle(120, "R2", "R9");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [2:0]  a;
            logic [15:0] d;
            logic        w;
            w = ($urandom % 6) == 0;
            a = 3'($urandom % 5);
            d = 16'($urandom);
            if (a <= 3'd1 && ($urandom % 4) != 0) d = d & 16'h000F;
            if (a == 3'd2 && ($urandom % 3) != 0) d = d & 16'hC3C3 & ~16'h4040;
            cyc(w, a, d, "R12", "R9");
            if ((n % 500) == 499) begin
                @(negedge clk); look_all("R2");
            end
        end
        @(negedge clk); look("R12", "R9");
        finish_run();
    end
endmodule